// File: doc/BRIEF.md
# Programmable IR Carrier Generator

This block produces the modulated carrier that drives an infrared remote-control emitter, all from the system clock. A fixed prescaler first divides the system clock by four to form a slower source tick. A period counter then divides that tick by a ratio of m times 2^n, with m set to 2 or 3 and n set to 0 through 3, and shapes each period into a high phase followed by a low phase. The high phase is half of the period or, for some ratios, one third.

A static mode input selects what the single output pin carries. In carrier mode, a port data bit gates the waveform: a 0 lets the carrier run and a 1 stops it and holds the pin low. Each time the carrier is let through, it begins with a full high phase. In level mode, the pin is a registered copy of the port data bit and the carrier counters stay idle. The configuration is meant to be static while the carrier runs. It is changed while the carrier is gated off.

Top module: `ir_carrier_gen`

## Requirements
- R1: While rst_n is low, carrier_out is 0 whatever the other inputs are.
- R2: While the carrier runs, the period counter advances once every 4 system clocks, so carrier_out can only change on clocks that are a multiple of 4 after the enable.
- R3: One carrier period lasts 4·m·2^n system clocks, where m is 2 when cfg_mul3=0 and 3 when cfg_mul3=1, and n is the unsigned value of cfg_exp[1:0].
- R4: With cfg_mul3=0, the high phase lasts half the period (4·2^n clocks), and cfg_third has no effect.
- R5: With cfg_mul3=1 and cfg_exp=0, the high phase lasts 4 of 12 clocks (one third), and cfg_third has no effect.
- R6: With cfg_mul3=1 and cfg_exp>0, cfg_third=1 gives a high phase of one third of the period (4·2^n clocks), and cfg_third=0 gives one half (6·2^n clocks).
- R7: In carrier mode (cfg_carrier_mode=1), port_bit=1 drives carrier_out to 0 on the next clock and holds both counters at zero.
- R8: When the carrier becomes enabled (carrier mode with port_bit=0), carrier_out is 1 from the next clock edge and the first high phase has its full length.
- R9: In level mode (cfg_carrier_mode=0), carrier_out equals port_bit as it was sampled at the previous clock edge.
- R10: carrier_out is a register output, with exactly one clock of latency from the inputs in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mul3 | input | 1 | Ratio multiplier select: 0 gives m=2, 1 gives m=3 |
| cfg_exp | input | 2 | Ratio exponent n (0 to 3) |
| cfg_third | input | 1 | Requests one-third duty where the ratio allows it |
| cfg_carrier_mode | input | 1 | 1 selects carrier mode, 0 selects level mode |
| port_bit | input | 1 | Port data bit: the carrier gate in carrier mode, the output level in level mode |
| carrier_out | output | 1 | Carrier or level output pin |

## Verification
The case most likely to break is a gate-off that lands on the same clock as the period counter's wrap from its last count back to zero. When that happens, the hold-at-zero rule and the wrap both want to set the counter. This is provoked on purpose with bursts whose length is an exact multiple of the period, for every ratio and both duty settings. The burst is followed by a single-cycle gate-off and an immediate re-enable. The output is judged by a bench model that predicts an immediate low level and then a complete fresh high phase. A second collision, a mode switch on the same clock as the enable, is covered by random bursts that change mode and gate together.

// File: rtl/ir_carrier_pkg.sv
package ir_carrier_pkg;

    localparam int EXP_W      = 2;
    localparam int PRESC_DIV  = 4;
    localparam int MAX_RATIO  = 3 << ((1 << EXP_W) - 1);
    localparam int CNT_W      = $clog2(MAX_RATIO);

    typedef struct packed {
        logic             mul3;
        logic [EXP_W-1:0] exp;
        logic             third;
    } ratio_cfg_t;

endpackage

// File: rtl/ir_prescaler.sv
module ir_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [W-1:0] cnt;
    } presc_state_t;

    presc_state_t st_d, st_q;
    logic         last;

    always_comb begin
        st_d = st_q;
        last = (st_q.cnt == W'(DIV - 1));
        if (!run) begin
            st_d.cnt = '0;
        end else if (last) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + W'(1);
        end
    end

    assign tick = run && last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ir_period_ctr.sv
module ir_period_ctr
    import ir_carrier_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  ratio_cfg_t       cfg,
    output logic             phase_high,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } per_state_t;

    per_state_t       st_d, st_q;
    logic [CNT_W-1:0] ratio;
    logic [CNT_W-1:0] high_len;
    logic [CNT_W-1:0] base;

    always_comb begin
        base  = CNT_W'(1) << cfg.exp;
        ratio = cfg.mul3 ? (base + (base << 1)) : (base << 1);

        if (!cfg.mul3) begin
            high_len = base;
        end else if (cfg.exp == '0) begin
            high_len = CNT_W'(1);
        end else if (cfg.third) begin
            high_len = base;
        end else begin
            high_len = base + (base >> 1);
        end
    end

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt >= ratio - CNT_W'(1)) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    assign phase_high = (st_q.cnt < high_len);
    assign count      = st_q.cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
    import ir_carrier_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mul3,
    input  logic [EXP_W-1:0] cfg_exp,
    input  logic             cfg_third,
    input  logic             cfg_carrier_mode,
    input  logic             port_bit,
    output logic             carrier_out
);
    typedef struct packed {
        logic pin;
    } out_state_t;

    out_state_t       st_d, st_q;
    ratio_cfg_t       cfg;
    logic             run;
    logic             tick;
    logic             phase_high;
    logic [CNT_W-1:0] period_cnt;

    assign cfg = '{mul3: cfg_mul3, exp: cfg_exp, third: cfg_third};
    assign run = cfg_carrier_mode && !port_bit;

    ir_prescaler #(
        .DIV (PRESC_DIV)
    ) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    ir_period_ctr u_period (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .tick       (tick),
        .cfg        (cfg),
        .phase_high (phase_high),
        .count      (period_cnt)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_carrier_mode) begin
            st_d.pin = run && phase_high;
        end else begin
            st_d.pin = port_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign carrier_out = st_q.pin;
endmodule

// File: rtl/ir_carrier_gen_chk.sv
module ir_carrier_gen_chk
    import ir_carrier_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_carrier_mode,
    input logic             port_bit,
    input logic             carrier_out,
    input logic             run,
    input logic             tick,
    input logic [CNT_W-1:0] period_cnt
);
    p_reset_low_r1: assert property (@(posedge clk)
        !rst_n |=> (!rst_n |-> !carrier_out));

    p_hold_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_carrier_mode && port_bit) |=> !carrier_out);

    p_cnt_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (period_cnt == '0));

    p_start_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && period_cnt == '0 && !$past(run)) |=> carrier_out);

    p_level_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_carrier_mode |=> (carrier_out == $past(port_bit)));

    p_step_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> (period_cnt == $past(period_cnt)));

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        period_cnt < CNT_W'(MAX_RATIO));
endmodule

bind ir_carrier_gen ir_carrier_gen_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_carrier_mode (cfg_carrier_mode),
    .port_bit         (port_bit),
    .carrier_out      (carrier_out),
    .run              (run),
    .tick             (tick),
    .period_cnt       (period_cnt)
);

// File: tb/ir_carrier_gen_test.sv
`timescale 1ns/1ps
module ir_carrier_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_mul3 = 1'b0;
    logic [1:0] cfg_exp = 2'd0;
    logic       cfg_third = 1'b0;
    logic       cfg_carrier_mode = 1'b0;
    logic       port_bit = 1'b1;
    logic       carrier_out;

    int n_checks = 0;
    int n_fails  = 0;
    int run_k    = 0;

    always #2.5 clk = ~clk;

    ir_carrier_gen uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_mul3         (cfg_mul3),
        .cfg_exp          (cfg_exp),
        .cfg_third        (cfg_third),
        .cfg_carrier_mode (cfg_carrier_mode),
        .port_bit         (port_bit),
        .carrier_out      (carrier_out)
    );

    function automatic int ratio_of(input logic m3, input logic [1:0] n);
        return (m3 ? 3 : 2) * (1 << n);
    endfunction

    function automatic int high_of(input logic m3, input logic [1:0] n, input logic th);
        int r = ratio_of(m3, n);
        if (!m3)        return r / 2;
        else if (n == 0) return 1;
        else if (th)    return r / 3;
        else            return r / 2;
    endfunction

    task automatic check(input logic got, input logic exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: carrier_out=%0b expected=%0b (t=%0t)", tag, got, exp, $time);
        end
    endtask

    task automatic cyc(input logic mode, input logic pb, input logic m3,
                       input logic [1:0] n, input logic th);
        logic  ex;
        string tag;
        int    per, hi, p;
        @(negedge clk);
        cfg_carrier_mode = mode;
        port_bit         = pb;
        cfg_mul3         = m3;
        cfg_exp          = n;
        cfg_third        = th;
        @(posedge clk);
        #1;
        if (mode && !pb) begin
            per = 4 * ratio_of(m3, n);
            hi  = 4 * high_of(m3, n, th);
            p   = run_k % per;
            ex  = (p < hi);
            if (run_k == 0)              tag = "R8";
            else if (p == 0)             tag = "R3";
            else if (p % 4 == 2)         tag = "R2";
            else if (!m3)                tag = "R4";
            else if (n == 0)             tag = "R5";
            else                         tag = "R6";
            run_k++;
        end else begin
            ex    = mode ? 1'b0 : pb;
            tag   = mode ? "R7" : "R9 R10";
            run_k = 0;
        end
        check(carrier_out, ex, tag);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int unsigned seed_set;
        seed_set = $urandom(32'd20240611);
        // R1: reset with level mode and port_bit high must still give low
        repeat (3) begin
            @(posedge clk);
            #1;
            check(carrier_out, 1'b0, "R1");
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R9/R10: level mode toggles
        cyc(1'b0, 1'b1, 1'b0, 2'd0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
        cyc(1'b0, 1'b1, 1'b1, 2'd3, 1'b1);
        cyc(1'b0, 1'b0, 1'b1, 2'd3, 1'b1);

        // Directed: every ratio, both duty requests, wrap-coincident gate-off
        for (int m = 0; m < 2; m++) begin
            for (int n = 0; n < 4; n++) begin
                for (int t = 0; t < 2; t++) begin
                    int per = 4 * ratio_of(m[0], n[1:0]);
                    cyc(1'b1, 1'b1, m[0], n[1:0], t[0]);
                    repeat (2 * per) cyc(1'b1, 1'b0, m[0], n[1:0], t[0]);
                    cyc(1'b1, 1'b1, m[0], n[1:0], t[0]);        // R7 at wrap
                    repeat (per + 1) cyc(1'b1, 1'b0, m[0], n[1:0], t[0]);
                    cyc(1'b1, 1'b1, m[0], n[1:0], t[0]);
                end
            end
        end

        // Mode switch on the same clock as enable, and back
        cyc(1'b0, 1'b0, 1'b1, 2'd1, 1'b1);
        repeat (30) cyc(1'b1, 1'b0, 1'b1, 2'd1, 1'b1);
        cyc(1'b0, 1'b0, 1'b1, 2'd1, 1'b1);
        cyc(1'b1, 1'b0, 1'b1, 2'd1, 1'b1);

        // Constrained random bursts; configuration changes only while gated off
        for (int b = 0; b < 300; b++) begin
            logic       m3, th, mode;
            logic [1:0] n;
            int         len, gap;
            m3   = 1'($urandom);
            n    = 2'($urandom);
            th   = 1'($urandom);
            mode = ($urandom % 4) != 0;
            len  = 1 + ($urandom % 160);
            gap  = 1 + ($urandom % 6);
            if (mode) begin
                repeat (len) cyc(1'b1, 1'b0, m3, n, th);
                repeat (gap) cyc(1'b1, 1'b1, m3, n, th);
            end else begin
                repeat (len % 20 + 1) cyc(1'b0, 1'($urandom), m3, n, th);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule